// File: doc/BRIEF.md
# Level Interrupt Request Capture

This block gathers interrupt requests from a set of active-low, level-sensitive request pins and from a 4-bit active-low encoded priority bus. It presents one request line and a priority level to the processor. Each discrete pin passes through a synchronizer into a pending register. A per-source mask decides whether a pending bit can raise the request. A single-cycle accept pulse from the processor marks the moment an interrupt is taken.

A control bit selects how the pending register behaves. In the sticky mode, which is the reset default, a request seen on a pin is latched and held after the pin goes inactive. It stays held until the processor accepts any interrupt, until the source is masked, or until software writes a zero to its bit after the pin has gone inactive. In the transparent mode, the pending register simply follows the synchronized pin and holds nothing.

The encoded bus carries two 4-pin groups, and a control bit picks the group. The selected group is inverted to give the level, so all pins low means level 15 and all pins high means no request. A new level takes effect only after two matching synchronized samples. All discrete sources share one programmable priority. The level reported to the processor is the larger of that priority, when an unmasked bit is pending, and the encoded level.

Top module: `lvl_irq_capture`

## Requirements
- R1: After reset the register reads are: pending 0, mask 0, control 0 (sticky mode, lower group), priority 8. With all pins high, irq_req_o is 0 and irq_level_o is 0.
- R2: In sticky mode (control bit 0 = 0), an unmasked pin held low sets its pending bit on the third rising clock edge after the change. The bit stays set after the pin returns high.
- R3: In sticky mode, an accept_i pulse clears every pending bit whose pin is inactive, whichever source the accepted interrupt came from. A bit whose pin is still active stays set.
- R4: A set mask bit (register 1, 1 = masked) keeps that source from raising irq_req_o. In sticky mode it clears the stored bit on the edge after the mask takes effect and blocks new capture.
- R5: A write to the pending register (address 0) clears each bit written as 0 whose synchronized pin is inactive. Writing 1 has no effect, and writing 0 while the pin is still active leaves the bit set.
- R6: In transparent mode (control bit 0 = 1), each pending bit equals its synchronized pin level one edge later. It is not held after the pin goes high, and writing 0 while the pin is active does not clear it.
- R7: The encoded level is the bitwise inverse of the selected 4-pin group. Control bit 1 = 0 selects bus bits 3:0 and 1 selects bits 7:4. All low gives 15 and all high gives 0.
- R8: A new encoded value appears at irq_level_o on the fourth rising edge after the bus changes. A value held for only one cycle is never taken.
- R9: irq_req_o is 1 when any unmasked pending bit is set or the encoded level is nonzero. irq_level_o is the larger of the encoded level and, when an unmasked bit is pending, the programmable priority in register 3 bits 3:0.
- R10: The registers are at address 0 (pending), 1 (mask), 2 (control: bit 0 mode, bit 1 group) and 3 (priority). Each reads back through reg_rdata_o combinationally from reg_addr_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_n_i | input | NUM_SRC | Discrete level request pins, active low |
| enc_bus_n_i | input | GROUPS*LVL_W | Encoded priority bus, active low, grouped in nibbles |
| accept_i | input | 1 | Processor accept pulse, one cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data |
| irq_req_o | output | 1 | Request to processor |
| irq_level_o | output | LVL_W | Priority level of the request |

## Verification
The bound checker watches the pending register on every cycle. In transparent mode it checks that the register tracks the synchronized pins. In sticky mode it checks that unmasked stored bits persist when no accept or clear arrives, that an accept leaves only still-active pins, and that masked bits are empty. It also checks that the output level never falls below the encoded level and is zero whenever no request is raised. The bench scenarios cover the rest. These are the exact synchronizer and filter latencies, rejection of a one-cycle bus glitch, group selection, the order in which software must remove a pin before clearing its bit, and how the shared priority and the encoded level combine.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
   typedef enum logic [1:0] {
      REG_PEND = 2'd0,
      REG_MASK = 2'd1,
      REG_CTRL = 2'd2,
      REG_PRIO = 2'd3
   } lirq_reg_e;

   localparam int CTRL_MODE_BIT = 0;
   localparam int CTRL_GRP_LSB  = 1;
endpackage

// File: rtl/lirq_sync.sv
module lirq_sync #(
   parameter int   WIDTH   = 1,
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("lirq_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("lirq_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg_q[k] <= {WIDTH{RST_VAL}};
      end else begin
         stg_q[0] <= d_i;
         for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lirq_pend.sv
module lirq_pend #(
   parameter int NUM_SRC = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] act_i,
   input  logic [NUM_SRC-1:0] mask_i,
   input  logic               transparent_i,
   input  logic               accept_i,
   input  logic [NUM_SRC-1:0] swclr_i,
   output logic [NUM_SRC-1:0] pend_o
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
      logic bit_q;
      logic set_w;
      logic clr_w;

      always_comb begin
         set_w = act_i[i] & ~mask_i[i];
         clr_w = accept_i | swclr_i[i] | mask_i[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            bit_q <= 1'b0;
         end else if (transparent_i) begin
            bit_q <= act_i[i];
         end else begin
            bit_q <= set_w | (bit_q & ~clr_w);
         end
      end

      assign pend_o[i] = bit_q;
   end
endmodule

// File: rtl/lirq_enc.sv
module lirq_enc #(
   parameter int LVL_W  = 4,
   parameter int GROUPS = 2,
   parameter int GSEL_W = 1,
   parameter int STAGES = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [GROUPS*LVL_W-1:0] bus_n_i,
   input  logic [GSEL_W-1:0]       grp_i,
   output logic [LVL_W-1:0]        lvl_o
);
   logic [LVL_W-1:0] sel_n;
   logic [LVL_W-1:0] sync_n;
   logic [LVL_W-1:0] prev_q;
   logic [LVL_W-1:0] lvl_q;

   always_comb begin
      sel_n = '1;
      for (int g = 0; g < GROUPS; g++) begin
         if (grp_i == GSEL_W'(g)) sel_n = bus_n_i[g*LVL_W +: LVL_W];
      end
   end

   lirq_sync #(
      .WIDTH  (LVL_W),
      .STAGES (STAGES),
      .RST_VAL(1'b1)
   ) sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (sel_n),
      .q_o  (sync_n)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '1;
         lvl_q  <= '0;
      end else begin
         prev_q <= sync_n;
         if (sync_n == prev_q) lvl_q <= ~sync_n;
      end
   end

   assign lvl_o = lvl_q;
endmodule

// File: rtl/lirq_regs.sv
module lirq_regs
   import lirq_pkg::*;
#(
   parameter int NUM_SRC  = 4,
   parameter int DATA_W   = 8,
   parameter int LVL_W    = 4,
   parameter int GSEL_W   = 1,
   parameter int PRIO_RST = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               we_i,
   input  logic [1:0]         addr_i,
   input  logic [DATA_W-1:0]  wdata_i,
   input  logic [NUM_SRC-1:0] pend_i,
   output logic [NUM_SRC-1:0] mask_o,
   output logic               transparent_o,
   output logic [GSEL_W-1:0]  grp_o,
   output logic [LVL_W-1:0]   prio_o,
   output logic [NUM_SRC-1:0] swclr_o,
   output logic [DATA_W-1:0]  rdata_o
);
   localparam int CTRL_W = 1 + GSEL_W;

   logic [NUM_SRC-1:0] mask_q;
   logic               mode_q;
   logic [GSEL_W-1:0]  grp_q;
   logic [LVL_W-1:0]   prio_q;
   logic [CTRL_W-1:0]  ctrl_w;
   lirq_reg_e          addr_e;

   assign addr_e = lirq_reg_e'(addr_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         mode_q <= 1'b0;
         grp_q  <= '0;
         prio_q <= LVL_W'(PRIO_RST);
      end else if (we_i) begin
         case (addr_e)
            REG_MASK: mask_q <= wdata_i[NUM_SRC-1:0];
            REG_CTRL: begin
               mode_q <= wdata_i[CTRL_MODE_BIT];
               grp_q  <= wdata_i[CTRL_GRP_LSB +: GSEL_W];
            end
            REG_PRIO: prio_q <= wdata_i[LVL_W-1:0];
            default:  ;
         endcase
      end
   end

   assign swclr_o = (we_i && addr_e == REG_PEND) ? ~wdata_i[NUM_SRC-1:0] : '0;
   assign ctrl_w  = {grp_q, mode_q};

   always_comb begin
      case (addr_e)
         REG_PEND: rdata_o = DATA_W'(pend_i);
         REG_MASK: rdata_o = DATA_W'(mask_q);
         REG_CTRL: rdata_o = DATA_W'(ctrl_w);
         default:  rdata_o = DATA_W'(prio_q);
      endcase
   end

   assign mask_o        = mask_q;
   assign transparent_o = mode_q;
   assign grp_o         = grp_q;
   assign prio_o        = prio_q;
endmodule

// File: rtl/lvl_irq_capture.sv
module lvl_irq_capture #(
   parameter int NUM_SRC  = 4,
   parameter int DATA_W   = 8,
   parameter int LVL_W    = 4,
   parameter int GROUPS   = 2,
   parameter int STAGES   = 2,
   parameter int PRIO_RST = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NUM_SRC-1:0]      irq_n_i,
   input  logic [GROUPS*LVL_W-1:0] enc_bus_n_i,
   input  logic                    accept_i,
   input  logic                    reg_we_i,
   input  logic [1:0]              reg_addr_i,
   input  logic [DATA_W-1:0]       reg_wdata_i,
   output logic [DATA_W-1:0]       reg_rdata_o,
   output logic                    irq_req_o,
   output logic [LVL_W-1:0]        irq_level_o
);
   localparam int GSEL_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;

   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_src
      $error("lvl_irq_capture: NUM_SRC must lie in 1..DATA_W");
   end
   if (LVL_W > DATA_W || 1 + GSEL_W > DATA_W) begin : g_bad_data
      $error("lvl_irq_capture: DATA_W too narrow for level or control fields");
   end
   if (GROUPS < 1) begin : g_bad_groups
      $error("lvl_irq_capture: GROUPS must be at least 1");
   end
   if (PRIO_RST < 0 || PRIO_RST >= (1 << LVL_W)) begin : g_bad_prio
      $error("lvl_irq_capture: PRIO_RST out of range for LVL_W");
   end

   logic [NUM_SRC-1:0] sync_n_w;
   logic [NUM_SRC-1:0] act_w;
   logic [NUM_SRC-1:0] pend_w;
   logic [NUM_SRC-1:0] mask_w;
   logic [NUM_SRC-1:0] swclr_w;
   logic               transparent_w;
   logic [GSEL_W-1:0]  grp_w;
   logic [LVL_W-1:0]   prio_w;
   logic [LVL_W-1:0]   enc_lvl_w;
   logic               disc_any_w;
   logic [LVL_W-1:0]   disc_lvl_w;

   lirq_sync #(
      .WIDTH  (NUM_SRC),
      .STAGES (STAGES),
      .RST_VAL(1'b1)
   ) pin_sync_i (
      .clk  (clk),
      .rst_n(rst_n),
      .d_i  (irq_n_i),
      .q_o  (sync_n_w)
   );

   assign act_w = ~sync_n_w;

   lirq_regs #(
      .NUM_SRC (NUM_SRC),
      .DATA_W  (DATA_W),
      .LVL_W   (LVL_W),
      .GSEL_W  (GSEL_W),
      .PRIO_RST(PRIO_RST)
   ) regs_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .we_i         (reg_we_i),
      .addr_i       (reg_addr_i),
      .wdata_i      (reg_wdata_i),
      .pend_i       (pend_w),
      .mask_o       (mask_w),
      .transparent_o(transparent_w),
      .grp_o        (grp_w),
      .prio_o       (prio_w),
      .swclr_o      (swclr_w),
      .rdata_o      (reg_rdata_o)
   );

   lirq_pend #(
      .NUM_SRC(NUM_SRC)
   ) pend_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .act_i        (act_w),
      .mask_i       (mask_w),
      .transparent_i(transparent_w),
      .accept_i     (accept_i),
      .swclr_i      (swclr_w),
      .pend_o       (pend_w)
   );

   lirq_enc #(
      .LVL_W (LVL_W),
      .GROUPS(GROUPS),
      .GSEL_W(GSEL_W),
      .STAGES(STAGES)
   ) enc_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .bus_n_i(enc_bus_n_i),
      .grp_i  (grp_w),
      .lvl_o  (enc_lvl_w)
   );

   assign disc_any_w  = |(pend_w & ~mask_w);
   assign disc_lvl_w  = disc_any_w ? prio_w : '0;
   assign irq_level_o = (enc_lvl_w > disc_lvl_w) ? enc_lvl_w : disc_lvl_w;
   assign irq_req_o   = disc_any_w | (|enc_lvl_w);
endmodule

// File: rtl/lirq_chk.sv
module lirq_chk #(
   parameter int NUM_SRC = 4,
   parameter int LVL_W   = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic               transparent_w,
   input logic               accept_i,
   input logic [NUM_SRC-1:0] act_w,
   input logic [NUM_SRC-1:0] pend_w,
   input logic [NUM_SRC-1:0] mask_w,
   input logic [NUM_SRC-1:0] swclr_w,
   input logic [LVL_W-1:0]   enc_lvl_w,
   input logic               irq_req_o,
   input logic [LVL_W-1:0]   irq_level_o
);
   a_r6_transparent_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      transparent_w |=> (pend_w == $past(act_w)));

   a_r2_sticky_retains: assert property (@(posedge clk) disable iff (!rst_n)
      (!transparent_w && !accept_i && swclr_w == '0)
      |=> ((pend_w & $past(pend_w & ~mask_w)) == $past(pend_w & ~mask_w)));

   a_r3_accept_leaves_active: assert property (@(posedge clk) disable iff (!rst_n)
      (!transparent_w && accept_i) |=> (pend_w == $past(act_w & ~mask_w)));

   a_r4_mask_empties: assert property (@(posedge clk) disable iff (!rst_n)
      !transparent_w |=> ((pend_w & $past(mask_w)) == '0));

   a_r9_level_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (enc_lvl_w != '0) |-> (irq_req_o && irq_level_o >= enc_lvl_w));

   a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req_o |-> (irq_level_o == '0));
endmodule

bind lvl_irq_capture lirq_chk #(
   .NUM_SRC(NUM_SRC),
   .LVL_W  (LVL_W)
) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .transparent_w(transparent_w),
   .accept_i     (accept_i),
   .act_w        (act_w),
   .pend_w       (pend_w),
   .mask_w       (mask_w),
   .swclr_w      (swclr_w),
   .enc_lvl_w    (enc_lvl_w),
   .irq_req_o    (irq_req_o),
   .irq_level_o  (irq_level_o)
);

// File: tb/lvl_irq_capture_tb_top.sv
module lvl_irq_capture_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] irq_n = '1;
   logic [7:0] bus_n = '1;
   logic       accept = 1'b0;
   logic       we = 1'b0;
   logic [1:0] addr = '0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       req;
   logic [3:0] level;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   lvl_irq_capture dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_n_i    (irq_n),
      .enc_bus_n_i(bus_n),
      .accept_i   (accept),
      .reg_we_i   (we),
      .reg_addr_i (addr),
      .reg_wdata_i(wdata),
      .reg_rdata_o(rdata),
      .irq_req_o  (req),
      .irq_level_o(level)
   );

   // entry: {group, bus, expected level}
   localparam logic [12:0] ENC_TBL [7] = '{
      {1'b0, 8'hF0, 4'd15},
      {1'b0, 8'hFF, 4'd0},
      {1'b1, 8'h0F, 4'd15},
      {1'b1, 8'h5A, 4'd10},
      {1'b0, 8'h5A, 4'd5},
      {1'b1, 8'hFF, 4'd0},
      {1'b0, 8'h3E, 4'd1}
   };

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      addr = a; wdata = d; we = 1'b1;
      tick(1);
      we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic pulse_accept();
      accept = 1'b1;
      tick(1);
      accept = 1'b0;
   endtask

   initial begin
      #4_000_000;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [7:0] v;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      rd(2'd0, v); chk("R1 pending", v, 0);
      rd(2'd1, v); chk("R1 mask", v, 0);
      rd(2'd2, v); chk("R1 control", v, 0);
      rd(2'd3, v); chk("R1 priority", v, 8);
      chk("R1 req", req, 0);
      chk("R1 level", level, 0);

      // R7 table walk
      for (int e = 0; e < 7; e++) begin
         wr(2'd2, {6'd0, ENC_TBL[e][12], 1'b0});
         bus_n = ENC_TBL[e][11:4];
         tick(5);
         chk($sformatf("R7 entry %0d level", e), level, ENC_TBL[e][3:0]);
         chk($sformatf("R7 entry %0d req", e), req, ENC_TBL[e][3:0] != 0);
      end
      wr(2'd2, 8'h00);
      bus_n = 8'hFF;
      tick(5);

      // R8 glitch and latency
      bus_n = 8'hF0;
      tick(1);
      bus_n = 8'hFF;
      tick(5);
      chk("R8 glitch ignored", level, 0);
      bus_n = 8'hF7;
      tick(3);
      chk("R8 not yet after 3 edges", level, 0);
      tick(1);
      chk("R8 taken on 4th edge", level, 8);
      bus_n = 8'hFF;
      tick(5);

      // R2 sticky capture
      irq_n[0] = 1'b0;
      tick(2);
      rd(2'd0, v); chk("R2 not yet after 2 edges", v, 0);
      tick(1);
      rd(2'd0, v); chk("R2 set on 3rd edge", v, 1);
      irq_n[0] = 1'b1;
      tick(5);
      rd(2'd0, v); chk("R2 held after release", v, 1);
      chk("R9 req from stored bit", req, 1);
      chk("R9 level is priority", level, 8);

      // R5 software clear
      wr(2'd0, 8'hFF);
      rd(2'd0, v); chk("R5 write one no effect", v, 1);
      wr(2'd0, 8'h00);
      rd(2'd0, v); chk("R5 write zero clears", v, 0);
      irq_n[1] = 1'b0;
      tick(3);
      wr(2'd0, 8'h00);
      rd(2'd0, v); chk("R5 zero while active kept", v, 2);
      irq_n[1] = 1'b1;
      tick(3);
      wr(2'd0, 8'h00);
      rd(2'd0, v); chk("R5 clear after release", v, 0);

      // R3 accept clears any
      irq_n[0] = 1'b0; irq_n[2] = 1'b0;
      tick(3);
      irq_n[0] = 1'b1; irq_n[2] = 1'b1;
      tick(3);
      rd(2'd0, v); chk("R3 two stored", v, 5);
      pulse_accept();
      rd(2'd0, v); chk("R3 accept clears all", v, 0);
      irq_n[3] = 1'b0;
      tick(3);
      pulse_accept();
      rd(2'd0, v); chk("R3 active pin survives accept", v, 8);
      irq_n[3] = 1'b1;
      tick(3);
      pulse_accept();
      rd(2'd0, v); chk("R3 cleared after release", v, 0);

      // R4 masking
      irq_n[0] = 1'b0;
      tick(3);
      wr(2'd1, 8'h01);
      rd(2'd1, v); chk("R10 mask readback", v, 1);
      tick(1);
      rd(2'd0, v); chk("R4 mask clears stored", v, 0);
      chk("R4 masked no req", req, 0);
      irq_n[0] = 1'b1;
      tick(3);
      wr(2'd1, 8'h00);
      rd(2'd0, v); chk("R4 nothing captured while masked", v, 0);

      // R9 level combination
      bus_n = 8'hF9;
      tick(5);
      chk("R9 encoded level", level, 6);
      irq_n[2] = 1'b0;
      tick(3);
      chk("R9 max picks priority", level, 8);
      wr(2'd3, 8'h03);
      chk("R9 max picks encoded", level, 6);
      irq_n[2] = 1'b1;
      tick(3);
      wr(2'd0, 8'h00);
      chk("R9 encoded only", level, 6);
      chk("R9 req from encoded", req, 1);
      bus_n = 8'hFF;
      tick(5);
      chk("R9 idle req", req, 0);
      chk("R9 idle level", level, 0);
      wr(2'd3, 8'h08);
      rd(2'd3, v); chk("R10 priority readback", v, 8);

      // R6 transparent mode
      wr(2'd2, 8'h01);
      rd(2'd2, v); chk("R10 control readback", v, 1);
      irq_n[1] = 1'b0;
      tick(3);
      rd(2'd0, v); chk("R6 follows active", v, 2);
      wr(2'd0, 8'h00);
      rd(2'd0, v); chk("R6 write zero ignored", v, 2);
      irq_n[1] = 1'b1;
      tick(3);
      rd(2'd0, v); chk("R6 not held", v, 0);
      chk("R6 no req", req, 0);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule